// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a port I/O access of one, two or four bytes may proceed. It first checks the task-state segment descriptor taken from the task register: the present flag, the 4-bit type and the segment limit. If the descriptor is usable, the block reads the 16-bit bitmap offset from the segment, works out which bytes of the permission bitmap cover the port, and reads a 16-bit window there. It allows the access only when every permission bit the access covers is clear.

Every rejection is reported as a general-protection fault with error code 0. The caller pulses `start` with the descriptor fields, the port number and the access size. It then waits for the one-cycle `done` pulse, which comes with exactly one of `allow` or `gp_fault` set. Memory is reached through a 16-bit read port. `mem_req` stays high, with a constant address, until the memory answers with `mem_valid`.

The controller has four states. IDLE waits for start. It moves to FETCH_OFS when the descriptor and size code are good, and to DONE (fault) when they are not. FETCH_OFS reads the offset word. On valid it moves to FETCH_MAP if the two-byte window fits in the limit, and to DONE (fault) if it does not. FETCH_MAP reads the window and moves to DONE on valid, with the verdict. DONE lasts one cycle and returns to IDLE.

Top module: `io_perm_checker`

## Requirements
- R1: A start with the present flag low, a type other than 9, or a limit below 103 ends in a fault without any memory request.
- R2: The size code is 0 for byte, 1 for word and 2 for dword. Code 3 ends in a fault without any memory request.
- R3: The first read is at descriptor base + 0x66. Read data is little-endian: bits 7:0 come from the lower byte address.
- R4: The byte position is the offset word plus the port shifted right by 3. The check faults after that single read when position + 1 is greater than the limit, and goes on when position + 1 equals the limit.
- R5: The second read is at descriptor base + byte position.
- R6: The window read is shifted right by port bits 2:0 and masked with 1, 3 or 15 for byte, word or dword. The access is allowed only if the masked bits are all zero, and the mask may cover bits of both bytes of the window.
- R7: `done` is a single-cycle pulse with exactly one of `allow` or `gp_fault` high, and `fault_code` is 0.
- R8: The byte position is computed in 17 bits. A sum past 0xFFFF does not wrap, and it faults against a limit of 0xFFFF.
- R9: Descriptor, port and size are captured at start. A start or input change while a check is running has no effect on it.
- R10: After reset, `done`, `allow`, `gp_fault` and `mem_req` are low.
- R11: While `mem_req` is high and `mem_valid` is low, the request and its address stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check (taken in IDLE only) |
| seg_present | input | 1 | Descriptor present flag |
| seg_type | input | 4 | Descriptor type field |
| seg_base | input | 32 | Segment base address |
| seg_limit | input | 32 | Segment limit (last valid byte offset) |
| port_addr | input | 16 | I/O port number |
| acc_size | input | 2 | Access size code |
| mem_req | output | 1 | Read request, held until valid |
| mem_addr | output | 32 | Read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data, little-endian |
| done | output | 1 | One-cycle completion pulse |
| allow | output | 1 | Access permitted (with done) |
| gp_fault | output | 1 | General-protection fault (with done) |
| fault_code | output | 16 | Fault error code, always 0 |

## Verification
A wrong state or a lost captured value shows up at the ports within one memory round trip. A stuck FSM holds `mem_req` with no `done`. A skipped stage either issues too few reads or pulses `done` too early. A bad position or shift shows as a wrong `mem_addr` on the second read, or as the wrong verdict in the `done` cycle. The bench logs every read address and counts reads per check, so a descriptor-stage fault that still touches memory is caught on that same check.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FETCH_OFS = 2'd1,
        ST_FETCH_MAP = 2'd2,
        ST_DONE      = 2'd3
    } chk_state_t;

    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_WORD  = 2'd1;
    localparam logic [1:0] SZ_DWORD = 2'd2;

    localparam logic [3:0] TSS_AVAIL_TYPE = 4'd9;
    localparam int unsigned MIN_SEG_LIMIT = 103;
    localparam int unsigned OFS_FIELD_POS = 'h66;

endpackage

// File: rtl/io_perm_desc_gate.sv
module io_perm_desc_gate
    import io_perm_pkg::*;
#(
    parameter int LIM_W = 32
) (
    input  logic             present,
    input  logic [3:0]       seg_type,
    input  logic [LIM_W-1:0] limit,
    input  logic [1:0]       size_code,
    output logic             usable
);
    logic type_ok;
    logic lim_ok;
    logic size_ok;

    always_comb begin
        type_ok = (seg_type == TSS_AVAIL_TYPE);
        lim_ok  = (limit >= LIM_W'(MIN_SEG_LIMIT));
        size_ok = (size_code != 2'd3);
        usable  = present && type_ok && lim_ok && size_ok;
    end
endmodule

// File: rtl/io_perm_pos_calc.sv
module io_perm_pos_calc #(
    parameter int PORT_W = 16,
    parameter int LIM_W  = 32,
    parameter int POS_W  = PORT_W + 1
) (
    input  logic [15:0]       ofs_word,
    input  logic [PORT_W-1:0] port,
    input  logic [LIM_W-1:0]  limit,
    output logic [POS_W-1:0]  byte_pos,
    output logic              in_range
);
    localparam int END_W = POS_W + 1;
    localparam int CMP_W = (LIM_W > END_W) ? LIM_W : END_W;

    logic [END_W-1:0] last_byte;

    always_comb begin
        byte_pos  = POS_W'(ofs_word) + POS_W'(port >> 3);
        last_byte = END_W'(byte_pos) + END_W'(1);
        in_range  = (CMP_W'(last_byte) <= CMP_W'(limit));
    end
endmodule

// File: rtl/io_perm_window_eval.sv
module io_perm_window_eval
    import io_perm_pkg::*;
(
    input  logic [15:0] window,
    input  logic [2:0]  bit_ofs,
    input  logic [1:0]  size_code,
    output logic        all_clear
);
    logic [15:0] shifted;
    logic [3:0]  mask;

    always_comb begin
        shifted = window >> bit_ofs;
        unique case (size_code)
            SZ_BYTE:  mask = 4'b0001;
            SZ_WORD:  mask = 4'b0011;
            SZ_DWORD: mask = 4'b1111;
            default:  mask = 4'b1111;
        endcase
        all_clear = ((shifted[3:0] & mask) == 4'b0000);
    end
endmodule

// File: rtl/io_perm_checker.sv
module io_perm_checker
    import io_perm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 32,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              seg_present,
    input  logic [3:0]        seg_type,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [LIM_W-1:0]  seg_limit,
    input  logic [PORT_W-1:0] port_addr,
    input  logic [1:0]        acc_size,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [15:0]       mem_rdata,
    output logic              done,
    output logic              allow,
    output logic              gp_fault,
    output logic [15:0]       fault_code
);
    localparam int POS_W = PORT_W + 1;

    chk_state_t state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic [LIM_W-1:0]  limit_q;
    logic [PORT_W-1:0] port_q;
    logic [1:0]        size_q;
    logic [POS_W-1:0]  pos_q;
    logic              verdict_q;

    logic              desc_usable;
    logic [POS_W-1:0]  pos_calc;
    logic              pos_in_range;
    logic              win_clear;

    io_perm_desc_gate #(.LIM_W(LIM_W)) u_gate (
        .present   (seg_present),
        .seg_type  (seg_type),
        .limit     (seg_limit),
        .size_code (acc_size),
        .usable    (desc_usable)
    );

    io_perm_pos_calc #(.PORT_W(PORT_W), .LIM_W(LIM_W), .POS_W(POS_W)) u_pos (
        .ofs_word (mem_rdata),
        .port     (port_q),
        .limit    (limit_q),
        .byte_pos (pos_calc),
        .in_range (pos_in_range)
    );

    io_perm_window_eval u_win (
        .window    (mem_rdata),
        .bit_ofs   (port_q[2:0]),
        .size_code (size_q),
        .all_clear (win_clear)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = desc_usable ? ST_FETCH_OFS : ST_DONE;
            ST_FETCH_OFS: if (mem_valid) state_d = pos_in_range ? ST_FETCH_MAP : ST_DONE;
            ST_FETCH_MAP: if (mem_valid) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured operands and verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            limit_q   <= '0;
            port_q    <= '0;
            size_q    <= '0;
            pos_q     <= '0;
            verdict_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    base_q    <= seg_base;
                    limit_q   <= seg_limit;
                    port_q    <= port_addr;
                    size_q    <= acc_size;
                    verdict_q <= 1'b0;
                end
                ST_FETCH_OFS: if (mem_valid) begin
                    pos_q     <= pos_calc;
                    verdict_q <= 1'b0;
                end
                ST_FETCH_MAP: if (mem_valid) begin
                    verdict_q <= win_clear;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_addr   = '0;
        done       = 1'b0;
        allow      = 1'b0;
        gp_fault   = 1'b0;
        fault_code = 16'h0000;
        unique case (state_q)
            ST_FETCH_OFS: begin
                mem_req  = 1'b1;
                mem_addr = base_q + ADDR_W'(OFS_FIELD_POS);
            end
            ST_FETCH_MAP: begin
                mem_req  = 1'b1;
                mem_addr = base_q + ADDR_W'(pos_q);
            end
            ST_DONE: begin
                done     = 1'b1;
                allow    = verdict_q;
                gp_fault = !verdict_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/io_perm_sva.sv
module io_perm_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic              done,
    input logic              allow,
    input logic              gp_fault,
    input logic [15:0]       fault_code
);
    a_r7_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (allow ^ gp_fault));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> (fault_code == 16'h0000));

    a_r10_quiet_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!allow && !gp_fault));

    a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    a_r7_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);
endmodule

bind io_perm_checker io_perm_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .done       (done),
    .allow      (allow),
    .gp_fault   (gp_fault),
    .fault_code (fault_code)
);

// File: tb/io_perm_checker_tb_top.sv
`timescale 1ns/1ps
module io_perm_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        seg_present = 1'b1;
    logic [3:0]  seg_type = 4'd9;
    logic [31:0] seg_base = 32'h100;
    logic [31:0] seg_limit = 32'h200;
    logic [15:0] port_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid;
    logic [15:0] mem_rdata;
    logic        done, allow, gp_fault;
    logic [15:0] fault_code;

    int n_checks = 0;
    int n_fail = 0;
    int lat = 0;
    int rd_cnt = 0;
    int cnt = 0;
    logic [31:0] first_addr, last_addr;
    logic [7:0]  mem [0:1023];
    logic        got_allow, got_fault, got_done;
    logic [15:0] got_code;

    always #2.5 clk = ~clk;

    io_perm_checker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .seg_present(seg_present),
        .seg_type(seg_type), .seg_base(seg_base), .seg_limit(seg_limit),
        .port_addr(port_addr), .acc_size(acc_size), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .done(done), .allow(allow), .gp_fault(gp_fault), .fault_code(fault_code)
    );

    // memory responder with programmable latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_rdata <= '0;
            cnt       <= 0;
        end else if (mem_req && !mem_valid) begin
            if (cnt >= lat) begin
                mem_valid  <= 1'b1;
                mem_rdata  <= {mem[10'(mem_addr + 1)], mem[mem_addr[9:0]]};
                if (rd_cnt == 0) first_addr <= mem_addr;
                last_addr  <= mem_addr;
                rd_cnt     <= rd_cnt + 1;
                cnt        <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            mem_valid <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive a start pulse, then wait for done; rd_cnt reset at negedge while idle
    task automatic run(input logic [15:0] port, input logic [1:0] sz);
        @(negedge clk);
        rd_cnt    = 0;
        port_addr = port;
        acc_size  = sz;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_done = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (done) begin
                got_done  = 1'b1;
                got_allow = allow;
                got_fault = gp_fault;
                got_code  = fault_code;
                break;
            end
            @(negedge clk);
        end
        chk(got_done, "R7 done seen", 32'(got_done), 32'd1);
    endtask

    task automatic expect_verdict(input bit exp_allow, input int exp_reads, input string tag);
        chk(got_allow == exp_allow && got_fault == !exp_allow, tag, {got_allow, got_fault}, {exp_allow, !exp_allow});
        chk(rd_cnt == exp_reads, {tag, " reads"}, rd_cnt, exp_reads);
        chk(got_code == 16'h0, "R7 code", got_code, 0);
    endtask

    task automatic t_reset;
        chk(!done && !allow && !gp_fault && !mem_req, "R10 reset outputs",
            {done, allow, gp_fault, mem_req}, 0);
    endtask

    task automatic t_descriptor;
        seg_present = 1'b0; run(16'h000A, 2'd0); expect_verdict(0, 0, "R1 not present");
        seg_present = 1'b1; seg_type = 4'hB; run(16'h000A, 2'd0); expect_verdict(0, 0, "R1 busy type");
        seg_type = 4'd9; seg_limit = 32'd102; run(16'h000A, 2'd0); expect_verdict(0, 0, "R1 limit 102");
        seg_limit = 32'd103; run(16'h0000, 2'd0); expect_verdict(0, 1, "R4 limit 103 passes gate, window past end");
        seg_limit = 32'h200;
    endtask

    task automatic t_size;
        run(16'h000A, 2'd3); expect_verdict(0, 0, "R2 size code 3");
    endtask

    task automatic t_bitmap;
        lat = 0;
        run(16'h000A, 2'd0); expect_verdict(1, 2, "R6 byte clear");
        chk(first_addr == 32'h166, "R3 offset addr", first_addr, 32'h166);
        chk(last_addr == 32'h169, "R5 window addr", last_addr, 32'h169);
        lat = 2;
        run(16'h000E, 2'd2); expect_verdict(0, 2, "R6 dword crosses byte");
        run(16'h000E, 2'd1); expect_verdict(1, 2, "R6 word clear");
        run(16'h000F, 2'd2); expect_verdict(0, 2, "R6 dword shift 7");
        run(16'h0011, 2'd0); expect_verdict(0, 2, "R6 byte set");
        chk(last_addr == 32'h16A, "R5 window addr 2", last_addr, 32'h16A);
        lat = 0;
    endtask

    task automatic t_limit;
        seg_limit = 32'h6A; run(16'h0008, 2'd0); expect_verdict(1, 2, "R4 end equals limit");
        seg_limit = 32'h69; run(16'h0008, 2'd0); expect_verdict(0, 1, "R4 end past limit");
        seg_limit = 32'h200;
    endtask

    task automatic t_wrap;
        mem[10'h166] = 8'hFF; mem[10'h167] = 8'hFF;
        seg_limit = 32'hFFFF; run(16'h0008, 2'd0); expect_verdict(0, 1, "R8 no wrap at 0xFFFF");
        seg_limit = 32'h10001; run(16'h0008, 2'd0);
        chk(rd_cnt == 2 && last_addr == 32'h10100, "R8 17-bit position addr", last_addr, 32'h10100);
        mem[10'h166] = 8'h68; mem[10'h167] = 8'h00;
        seg_limit = 32'h200;
    endtask

    task automatic t_busy;
        int extra;
        lat = 3;
        @(negedge clk);
        rd_cnt = 0; port_addr = 16'h000A; acc_size = 2'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        port_addr = 16'h0011; acc_size = 2'd3; seg_present = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        got_done = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (done) begin got_done = 1'b1; got_allow = allow; got_fault = gp_fault; got_code = fault_code; break; end
            @(negedge clk);
        end
        seg_present = 1'b1;
        chk(got_done, "R9 done seen", 32'(got_done), 1);
        expect_verdict(1, 2, "R9 captured inputs");
        extra = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (done) extra++; end
        chk(extra == 0, "R9 second start ignored", extra, 0);
        lat = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        mem[10'h166] = 8'h68; mem[10'h167] = 8'h00;
        mem[10'h16A] = 8'h02;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_descriptor();
        t_size();
        t_bitmap();
        t_limit();
        t_wrap();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule